// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit takes one 32-bit branch instruction word and decides, in one registered step, whether the branch is taken and where the program continues. Alongside the instruction it receives the following:

- the word that follows it, which holds a full displacement for the long formats;
- the address of the branch itself;
- the value of the index register that the instruction names;
- the V, N and Z status flags.

The surrounding pipeline fetches the instruction and the following word and reads the register file. This unit does not do those tasks and only resolves the branch.

Four branch opcodes are recognised, and each is either long or quick and either PC-relative or register-indexed:

| Opcode | Form | Target |
|---|---|---|
| 0x40 | long, PC-relative | PC plus the following word |
| 0x41 | long, indexed | index register plus the following word |
| 0x50 | quick, PC-relative | PC plus the sign-extended low byte |
| 0x51 | quick, indexed | index register plus the sign-extended low byte |

A four-bit condition mask selects any subset of the three flags. Its top bit sets the polarity that the OR of the selected flags must match. A mask of all zeros is therefore an unconditional branch, and a mask of 1000 never branches.

Addresses count words, and `PC_STEP` sets the size of one instruction word in address units. The unit reports a taken flag, the branch target and the next program counter. It also reports whether the following word was consumed as a displacement, and a flag for any word that is not one of the four branches. Results appear one clock after a valid input and hold while no new input is presented.

Top module: `brk_resolve`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `taken`, `not_branch` and `disp_used` are 0 and `target` and `next_pc` are 0.
- R2: `out_valid` is `in_valid` delayed by one clock. When `in_valid` is low, every other output keeps its previous value.
- R3: The mask is bits 19 (polarity i), 18 (v), 17 (n) and 16 (z). The condition is (V and v) or (N and n) or (Z and z). A branch opcode is taken exactly when the condition equals i.
- R4: Opcode 0x40 (bits 31..24) gives `target` = `pc` + `ext_word` and `disp_used` = 1.
- R5: Opcode 0x41 gives `target` = `idx_val` + `ext_word` and `disp_used` = 1.
- R6: Opcode 0x50 gives `target` = `pc` + the sign-extended bits 7..0 and `disp_used` = 0.
- R7: Opcode 0x51 gives `target` = `idx_val` + the sign-extended bits 7..0 and `disp_used` = 0.
- R8: `next_pc` is `target` when taken. When not taken, it is `pc` + 2·`PC_STEP` for 0x40/0x41 and `pc` + `PC_STEP` for 0x50/0x51 (default `PC_STEP` = 1).
- R9: Any other opcode gives `not_branch` = 1, `taken` = 0, `disp_used` = 0, `target` = 0 and `next_pc` = `pc` + `PC_STEP`.
- R10: Bits 23..20 and 15..8 never affect any output. Bits 7..0 do not affect the long formats, and `ext_word` does not affect the quick formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a branch to resolve this cycle |
| instr | input | 32 | Instruction word |
| ext_word | input | 32 | Following word, long displacement |
| pc | input | 32 | Address of the instruction |
| idx_val | input | 32 | Index register value |
| flag_v | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| out_valid | output | 1 | Result registers hold a new result |
| taken | output | 1 | Branch is taken |
| target | output | 32 | Branch destination |
| next_pc | output | 32 | Address of the next instruction to fetch |
| disp_used | output | 1 | Following word was consumed as displacement |
| not_branch | output | 1 | Opcode is not a branch |

## Verification
All sixteen masks are crossed with all eight flag combinations. This separates the choice of flags from the polarity inversion and exposes any wrong bit position in the mask. Each of the four formats is tried with:

- positive, negative and boundary displacements, which show whether sign extension is applied and whether the PC or the index register is the base;
- the taken and not-taken cases, which separate the one-word and two-word fall-through.

Non-branch opcodes adjacent to the valid ones (0x3F, 0x42, 0x4F, 0x52) check the opcode compare. The same word is then replayed with its ignored fields and unused inputs flipped.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int IMM_W = 8;

  localparam logic [7:0] OP_REL_LONG  = 8'h40;
  localparam logic [7:0] OP_IDX_LONG  = 8'h41;
  localparam logic [7:0] OP_REL_QUICK = 8'h50;
  localparam logic [7:0] OP_IDX_QUICK = 8'h51;

  typedef enum logic [2:0] {
    FMT_NONE,
    FMT_REL_LONG,
    FMT_IDX_LONG,
    FMT_REL_QUICK,
    FMT_IDX_QUICK
  } fmt_e;

  typedef struct packed {
    fmt_e             fmt;
    logic             pol;   // polarity bit of the mask
    logic [2:0]       sel;   // {v, n, z} flag selects
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/brk_decode.sv
module brk_decode
  import brk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  localparam int OPC_LO  = XLEN - 8;
  localparam int MASK_HI = 19;
  localparam int MASK_LO = 16;

  logic [7:0] opc;
  logic       unused_fields;

  assign opc           = instr[XLEN-1:OPC_LO];
  assign unused_fields = ^{instr[OPC_LO-1:MASK_HI+1], instr[MASK_LO-1:IMM_W]};

  always_comb begin
    dec.pol = instr[MASK_HI];
    dec.sel = instr[MASK_HI-1:MASK_LO];
    dec.imm = instr[IMM_W-1:0];
    unique case (opc)
      OP_REL_LONG:  dec.fmt = FMT_REL_LONG;
      OP_IDX_LONG:  dec.fmt = FMT_IDX_LONG;
      OP_REL_QUICK: dec.fmt = FMT_REL_QUICK;
      OP_IDX_QUICK: dec.fmt = FMT_IDX_QUICK;
      default:      dec.fmt = FMT_NONE;
    endcase
  end
endmodule

// File: rtl/brk_cond.sv
module brk_cond #(
  parameter int NFLAGS = 3
) (
  input  logic [NFLAGS-1:0] sel,
  input  logic [NFLAGS-1:0] flags,
  input  logic              pol,
  output logic              pass
);
  logic [NFLAGS-1:0] lane;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_lane
    assign lane[g] = sel[g] & flags[g];
  end

  assign pass = ((|lane) == pol);
endmodule

// File: rtl/brk_target.sv
module brk_target
  import brk_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 1
) (
  input  fmt_e             fmt,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  idx_val,
  input  logic [XLEN-1:0]  ext_word,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  fallthru,
  output logic             is_long,
  output logic             is_branch
);
  localparam logic [XLEN-1:0] STEP1 = XLEN'(PC_STEP);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * PC_STEP);

  logic            use_idx;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;
  logic [XLEN-1:0] imm_sx;

  assign is_branch = (fmt != FMT_NONE);
  assign is_long   = (fmt == FMT_REL_LONG) || (fmt == FMT_IDX_LONG);
  assign use_idx   = (fmt == FMT_IDX_LONG) || (fmt == FMT_IDX_QUICK);
  assign imm_sx    = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign base      = use_idx ? idx_val : pc;
  assign offs      = is_long ? ext_word : imm_sx;
  assign target    = is_branch ? (base + offs) : '0;
  assign fallthru  = pc + (is_long ? STEP2 : STEP1);
endmodule

// File: rtl/brk_resolve.sv
module brk_resolve
  import brk_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] ext_word,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] idx_val,
  input  logic            flag_v,
  input  logic            flag_n,
  input  logic            flag_z,
  output logic            out_valid,
  output logic            taken,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] next_pc,
  output logic            disp_used,
  output logic            not_branch
);
  localparam int NFLAGS = 3;

  dec_t            dec;
  logic            cond_pass;
  logic [XLEN-1:0] tgt_c;
  logic [XLEN-1:0] fall_c;
  logic            long_c;
  logic            br_c;
  logic            take_c;

  brk_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  brk_cond #(.NFLAGS(NFLAGS)) u_cond (
    .sel   (dec.sel),
    .flags ({flag_v, flag_n, flag_z}),
    .pol   (dec.pol),
    .pass  (cond_pass)
  );

  brk_target #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_tgt (
    .fmt       (dec.fmt),
    .pc        (pc),
    .idx_val   (idx_val),
    .ext_word  (ext_word),
    .imm       (dec.imm),
    .target    (tgt_c),
    .fallthru  (fall_c),
    .is_long   (long_c),
    .is_branch (br_c)
  );

  assign take_c = br_c & cond_pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      target     <= '0;
      next_pc    <= '0;
      disp_used  <= 1'b0;
      not_branch <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken      <= take_c;
        target     <= tgt_c;
        next_pc    <= take_c ? tgt_c : fall_c;
        disp_used  <= br_c & long_c;
        not_branch <= ~br_c;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(taken) && $stable(target) && $stable(next_pc));
  assert_always_mask_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:24] == OP_REL_QUICK) && (instr[19:16] == 4'b0000) |=> taken);
  assert_never_mask_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:24] == OP_IDX_LONG) && (instr[19:16] == 4'b1000) |=> !taken);
  assert_long_disp_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:24] == OP_REL_LONG) |=> disp_used && !not_branch);
  assert_taken_next_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && taken |-> next_pc == target);
  assert_nonbranch_R9: assert property (@(posedge clk) disable iff (rst)
    not_branch |-> !taken && !disp_used);
endmodule

// File: tb/brk_resolve_tb.sv
`timescale 1ns/1ps
module brk_resolve_tb;
  localparam real CLK_NS = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, ext_word = '0, pc = '0, idx_val = '0;
  logic        flag_v = 1'b0, flag_n = 1'b0, flag_z = 1'b0;
  logic        out_valid, taken, disp_used, not_branch;
  logic [31:0] target, next_pc;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_NS/2) clk = ~clk;

  brk_resolve u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .ext_word(ext_word), .pc(pc), .idx_val(idx_val),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z),
    .out_valid(out_valid), .taken(taken), .target(target),
    .next_pc(next_pc), .disp_used(disp_used), .not_branch(not_branch)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent model of the requirements.
  task automatic model(input logic [31:0] w, input logic [31:0] ew,
                       input logic [31:0] p, input logic [31:0] x,
                       input logic [2:0] vnz,
                       output logic tk, output logic nb, output logic du,
                       output logic [31:0] tg, output logic [31:0] nx);
    logic c;
    logic [31:0] sx;
    c  = (vnz[2] & w[18]) | (vnz[1] & w[17]) | (vnz[0] & w[16]);
    sx = {{24{w[7]}}, w[7:0]};
    nb = 1'b0; du = 1'b0; tg = 32'd0;
    case (w[31:24])
      8'h40: begin tg = p + ew;  du = 1'b1; end
      8'h41: begin tg = x + ew;  du = 1'b1; end
      8'h50: tg = p + sx;
      8'h51: tg = x + sx;
      default: nb = 1'b1;
    endcase
    tk = !nb && (c == w[19]);
    nx = tk ? tg : (p + (du ? 32'd2 : 32'd1));
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] ew,
                       input logic [31:0] p, input logic [31:0] x,
                       input logic [2:0] vnz);
    @(negedge clk);
    in_valid = 1'b1; instr = w; ext_word = ew; pc = p; idx_val = x;
    {flag_v, flag_n, flag_z} = vnz;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input string req, input logic [31:0] w,
                          input logic [31:0] ew, input logic [31:0] p,
                          input logic [31:0] x, input logic [2:0] vnz);
    logic tk, nb, du;
    logic [31:0] tg, nx;
    model(w, ew, p, x, vnz, tk, nb, du, tg, nx);
    apply(w, ew, p, x, vnz);
    chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
    chk(req, "taken", {31'd0, taken}, {31'd0, tk});
    chk(req, "not_branch", {31'd0, not_branch}, {31'd0, nb});
    chk(req, "disp_used", {31'd0, disp_used}, {31'd0, du});
    chk(req, "target", target, tg);
    chk(req, "next_pc", next_pc, nx);
  endtask

  task automatic t_reset_R1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "taken", {31'd0, taken}, 32'd0);
    chk("R1", "not_branch", {31'd0, not_branch}, 32'd0);
    chk("R1", "disp_used", {31'd0, disp_used}, 32'd0);
    chk("R1", "target", target, 32'd0);
    chk("R1", "next_pc", next_pc, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_cond_sweep_R3;
    for (int m = 0; m < 16; m++)
      for (int f = 0; f < 8; f++)
        run_case("R3", {8'h50, 4'h0, m[3:0], 8'h00, 8'h10}, 32'h0, 32'h100, 32'h0, f[2:0]);
  endtask

  task automatic t_rel_long_R4;
    run_case("R4", 32'h4000_0000, 32'h0000_1000, 32'h0000_0200, 32'h5, 3'b000);
    run_case("R4", 32'h4000_0000, 32'hFFFF_FFF0, 32'h0000_0200, 32'h5, 3'b000);
    run_case("R8", 32'h4008_0000, 32'h0000_1000, 32'h0000_0200, 32'h5, 3'b000);
  endtask

  task automatic t_idx_long_R5;
    run_case("R5", 32'h4100_0300, 32'h0000_0040, 32'h0000_0200, 32'h8000_0000, 3'b000);
    run_case("R5", 32'h4104_0300, 32'h8000_0001, 32'h0000_0200, 32'h7FFF_FFFF, 3'b010);
    run_case("R8", 32'h4101_0300, 32'h0000_0040, 32'hFFFF_FFFF, 32'h1, 3'b000);
  endtask

  task automatic t_rel_quick_R6;
    run_case("R6", 32'h5000_007F, 32'hDEAD_BEEF, 32'h0000_1000, 32'h3, 3'b000);
    run_case("R6", 32'h5000_0080, 32'hDEAD_BEEF, 32'h0000_1000, 32'h3, 3'b000);
    run_case("R6", 32'h5000_00FF, 32'hDEAD_BEEF, 32'h0000_0000, 32'h3, 3'b000);
    run_case("R8", 32'h5008_00FF, 32'hDEAD_BEEF, 32'h0000_1000, 32'h3, 3'b000);
  endtask

  task automatic t_idx_quick_R7;
    run_case("R7", 32'h5100_0705, 32'h0, 32'h0000_1000, 32'h0000_2000, 3'b000);
    run_case("R7", 32'h5100_0780, 32'h0, 32'h0000_1000, 32'h0000_2000, 3'b000);
    run_case("R7", 32'h5101_0701, 32'h0, 32'h0000_1000, 32'hFFFF_FFFF, 3'b001);
  endtask

  task automatic t_nonbranch_R9;
    logic [7:0] ops [6] = '{8'h00, 8'h3F, 8'h42, 8'h4F, 8'h52, 8'hFF};
    for (int i = 0; i < 6; i++)
      run_case("R9", {ops[i], 24'h00_0012}, 32'h0000_0100, 32'h0000_0400, 32'h9, 3'b111);
  endtask

  task automatic t_ignored_R10;
    logic tk0;
    logic [31:0] tg0, nx0;
    apply(32'h5006_0A10, 32'h1111_1111, 32'h300, 32'h900, 3'b010);
    tk0 = taken; tg0 = target; nx0 = next_pc;
    apply(32'h50F6_F510, 32'hEEEE_EEEE, 32'h300, 32'h900, 3'b010);
    chk("R10", "quick taken", {31'd0, taken}, {31'd0, tk0});
    chk("R10", "quick target", target, tg0);
    chk("R10", "quick next_pc", next_pc, nx0);
    apply(32'h4102_0000, 32'h20, 32'h300, 32'h900, 3'b001);
    tk0 = taken; tg0 = target; nx0 = next_pc;
    apply(32'h41A2_5AFF, 32'h20, 32'h300, 32'h900, 3'b001);
    chk("R10", "long taken", {31'd0, taken}, {31'd0, tk0});
    chk("R10", "long target", target, tg0);
    chk("R10", "long next_pc", next_pc, nx0);
  endtask

  task automatic t_hold_R2;
    logic tk0;
    logic [31:0] tg0, nx0;
    apply(32'h4000_0000, 32'h77, 32'h1000, 32'h0, 3'b000);
    tk0 = taken; tg0 = target; nx0 = next_pc;
    instr = 32'h5108_0001; ext_word = 32'h5; pc = 32'hABCD; idx_val = 32'h1234;
    {flag_v, flag_n, flag_z} = 3'b111;
    @(negedge clk);
    chk("R2", "out_valid idle", {31'd0, out_valid}, 32'd0);
    chk("R2", "taken held", {31'd0, taken}, {31'd0, tk0});
    chk("R2", "target held", target, tg0);
    chk("R2", "next_pc held", next_pc, nx0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_cond_sweep_R3();
    t_rel_long_R4();
    t_idx_long_R5();
    t_rel_quick_R6();
    t_idx_quick_R7();
    t_nonbranch_R9();
    t_ignored_R10();
    t_hold_R2();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule